// File: doc/BRIEF.md
# AES Single-Round Vector Execution Unit

This unit computes one step of the AES block cipher on a 128-bit state per issued operation. A request carries a state operand A, a round-key operand B and an operation select. The select is a primary code, an extended code and a "last" bit. The unit can apply a full forward round, a forward final round, a full inverse round, an inverse final round, or a plain S-box substitution of A. The result is registered and appears one clock after the request. A core issues one such operation per round and keeps key expansion and round counting in software or in its sequencer.

The state is sixteen bytes. Byte 0 is the most significant byte of the 128-bit operand (bits 127:120). Byte k sits in column k/4, row k%4. A vector-unit enable input gates the unit. A request made while the unit is disabled gives a one-cycle unavailable flag in place of a result. A request with an encoding outside the five legal ones gives a one-cycle illegal flag.

Top module: `aesu_top`

## Requirements
- R1: Forward round (primary 4, extended 20, last=0): result = MixColumns(ShiftRows(SubBytes(A))) XOR B, where MixColumns uses coefficients {02,03,01,01} rotated right by the row index, over GF(2^8) modulo x^8+x^4+x^3+x+1.
- R2: Forward last round (primary 4, extended 20, last=1): result = ShiftRows(SubBytes(A)) XOR B.
- R3: Inverse round (primary 4, extended 21, last=0): result = InvMixColumns(InvSubBytes(InvShiftRows(A)) XOR B). The key is XORed before the inverse column mix, which uses coefficients {0E,0B,0D,09} rotated by the row index.
- R4: Inverse last round (primary 4, extended 21, last=1): result = InvSubBytes(InvShiftRows(A)) XOR B.
- R5: S-box operation (primary 4, extended 23): each byte of A goes through the forward AES S-box (00→63, 53→ED). B and the last bit have no effect.
- R6: Byte k of a 128-bit operand is bits [127-8k -: 8], in column k/4 and row k%4. ShiftRows output (col c, row r) takes input (col (c+r) mod 4, row r). InvShiftRows takes input (col (c-r) mod 4, row r).
- R7: The last bit selects the final-round variant in the extended-20 and extended-21 pairs.
- R8: A request with the enable low raises excUnavail for one cycle. It does not raise resValid and leaves result unchanged.
- R9: An enabled request whose primary code is not 4, or whose extended code is not 20, 21 or 23, raises excIllegal for one cycle. It does not raise resValid and leaves result unchanged.
- R10: resValid and the new result appear on the clock edge that samples the request. The result holds until the next legal enabled request.
- R11: A synchronous reset clears resValid, excUnavail, excIllegal and result.
- R12: At most one of resValid, excUnavail and excIllegal is high in any cycle. All three are low in the cycle after a clock with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vecEnable | input | 1 | Vector unit enabled |
| reqValid | input | 1 | Request strobe |
| reqPrimary | input | 6 | Primary operation code |
| reqExt | input | 6 | Extended operation code |
| reqLast | input | 1 | Final-round variant select |
| opA | input | 128 | State operand |
| opB | input | 128 | Round-key operand |
| resValid | output | 1 | Result updated this cycle |
| result | output | 128 | Registered result |
| excUnavail | output | 1 | Request made while disabled |
| excIllegal | output | 1 | Request with undefined encoding |

## Verification
The bench drives the inverse round with random keys. A design that applies the key after InvMixColumns instead of before it gives a different result on almost every operand. Known S-box values catch a wrong field polynomial or affine constant. A final-round round trip with a zero key must return A exactly, so a byte-order or row-rotation mix-up shows as a wrong lane. Disabled requests, bad primary and extended codes and an S-box request with a nonzero B and the last bit set are all checked for a correct flag and an untouched result. A unit that wrote the result anyway, or let B leak in, fails at once.

// File: rtl/aesu_pkg.sv
package aesu_pkg;
  localparam int DATA_W = 128;
  localparam int BYTE_W = 8;
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int NROWS = 4;
  localparam int NCOLS = NBYTES / NROWS;
  localparam int CODE_W = 6;
  localparam logic [CODE_W-1:0] PRIM_VEC = 6'd4;
  localparam logic [CODE_W-1:0] EXT_FWD = 6'd20;
  localparam logic [CODE_W-1:0] EXT_INV = 6'd21;
  localparam logic [CODE_W-1:0] EXT_SBOX = 6'd23;

  typedef struct packed {
    logic load;
    logic inverse;
    logic mix;
    logic sboxOnly;
  } aesuStrobe_t;

  function automatic logic [7:0] gfMul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc, cur;
    acc = 8'h00;
    cur = x;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ cur;
      cur = {cur[6:0], 1'b0} ^ (cur[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // x^254 is the multiplicative inverse; zero maps to zero
  function automatic logic [7:0] gfInv(input logic [7:0] x);
    logic [7:0] acc, base;
    logic [7:0] expo;
    acc = 8'h01;
    base = x;
    expo = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (expo[i]) acc = gfMul(acc, base);
      base = gfMul(base, base);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    logic [15:0] d;
    d = {x, x} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] sboxFwd(input logic [7:0] x);
    logic [7:0] v;
    v = gfInv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sboxInv(input logic [7:0] y);
    return gfInv(rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] mixCol(input logic [31:0] c, input logic inv);
    logic [7:0] s [4];
    logic [7:0] k [4];
    logic [31:0] o;
    for (int r = 0; r < 4; r++) s[r] = c[31-8*r -: 8];
    if (inv) begin
      k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09;
    end else begin
      k[0] = 8'h02; k[1] = 8'h03; k[2] = 8'h01; k[3] = 8'h01;
    end
    for (int r = 0; r < 4; r++) begin
      o[31-8*r -: 8] = gfMul(k[(4-r)%4], s[0]) ^ gfMul(k[(5-r)%4], s[1]) ^
                       gfMul(k[(6-r)%4], s[2]) ^ gfMul(k[(7-r)%4], s[3]);
    end
    return o;
  endfunction
endpackage

// File: rtl/aesu_ctrl.sv
module aesu_ctrl
  import aesu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vecEnable,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqPrimary,
  input  logic [CODE_W-1:0] reqExt,
  input  logic              reqLast,
  output aesuStrobe_t       strobe,
  output logic              resValid,
  output logic              excUnavail,
  output logic              excIllegal
);
  logic extKnown, legal, accept;

  always_comb begin
    extKnown = (reqExt == EXT_FWD) || (reqExt == EXT_INV) || (reqExt == EXT_SBOX);
    legal = (reqPrimary == PRIM_VEC) && extKnown;
    accept = reqValid && vecEnable && legal;
    strobe.load = accept;
    strobe.inverse = (reqExt == EXT_INV);
    strobe.mix = !reqLast;
    strobe.sboxOnly = (reqExt == EXT_SBOX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      excUnavail <= 1'b0;
      excIllegal <= 1'b0;
    end else begin
      resValid <= accept;
      excUnavail <= reqValid && !vecEnable;
      excIllegal <= reqValid && vecEnable && !legal;
    end
  end
endmodule

// File: rtl/aesu_datapath.sv
module aesu_datapath
  import aesu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  aesuStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  logic [BYTE_W-1:0] inA [NBYTES];
  logic [BYTE_W-1:0] fwdSub [NBYTES];
  logic [BYTE_W-1:0] invShift [NBYTES];
  logic [DATA_W-1:0] subV, fwdShiftV, invKeyedV, fwdMixV, invMixV;
  logic [DATA_W-1:0] nextResult;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    localparam int ROW = k % NROWS;
    localparam int COL = k / NROWS;
    localparam int FSRC = NROWS * ((COL + ROW) % NCOLS) + ROW;
    localparam int ISRC = NROWS * ((COL - ROW + NCOLS) % NCOLS) + ROW;
    localparam int HI = DATA_W - 1 - BYTE_W * k;
    assign inA[k] = opA[HI -: BYTE_W];
    assign fwdSub[k] = sboxFwd(inA[k]);
    assign invShift[k] = inA[ISRC];
    assign subV[HI -: BYTE_W] = fwdSub[k];
    assign fwdShiftV[HI -: BYTE_W] = fwdSub[FSRC];
    assign invKeyedV[HI -: BYTE_W] = sboxInv(invShift[k]) ^ opB[HI -: BYTE_W];
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    localparam int CHI = DATA_W - 1 - 32 * c;
    assign fwdMixV[CHI -: 32] = mixCol(fwdShiftV[CHI -: 32], 1'b0);
    assign invMixV[CHI -: 32] = mixCol(invKeyedV[CHI -: 32], 1'b1);
  end

  always_comb begin
    if (strobe.sboxOnly) nextResult = subV;
    else if (strobe.inverse) nextResult = strobe.mix ? invMixV : invKeyedV;
    else nextResult = (strobe.mix ? fwdMixV : fwdShiftV) ^ opB;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (strobe.load) result <= nextResult;
  end
endmodule

// File: rtl/aesu_top.sv
module aesu_top
  import aesu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vecEnable,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqPrimary,
  input  logic [CODE_W-1:0] reqExt,
  input  logic              reqLast,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              excUnavail,
  output logic              excIllegal
);
  aesuStrobe_t strobe;

  aesu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .vecEnable(vecEnable), .reqValid(reqValid),
    .reqPrimary(reqPrimary), .reqExt(reqExt), .reqLast(reqLast),
    .strobe(strobe), .resValid(resValid), .excUnavail(excUnavail),
    .excIllegal(excIllegal)
  );

  aesu_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .opA(opA), .opB(opB),
    .result(result)
  );
endmodule

// File: rtl/aesu_chk.sv
module aesu_chk
  import aesu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              vecEnable,
  input logic              reqValid,
  input logic [CODE_W-1:0] reqPrimary,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic              excUnavail,
  input logic              excIllegal
);
  // R12
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resValid, excUnavail, excIllegal}));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !resValid && !excUnavail && !excIllegal);

  // R8
  disabled_req_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid && !vecEnable |=> excUnavail && !resValid && $stable(result));

  // R9
  bad_primary_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid && vecEnable && (reqPrimary != PRIM_VEC) |=> excIllegal && $stable(result));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !resValid |-> $stable(result));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !resValid && !excUnavail && !excIllegal && (result == '0));
endmodule

bind aesu_top aesu_chk u_chk (
  .clk(clk), .rst(rst), .vecEnable(vecEnable), .reqValid(reqValid),
  .reqPrimary(reqPrimary), .resValid(resValid), .result(result),
  .excUnavail(excUnavail), .excIllegal(excIllegal)
);

// File: tb/aesu_top_test.sv
module aesu_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vecEnable = 1'b0;
  logic reqValid = 1'b0;
  logic [5:0] reqPrimary = '0;
  logic [5:0] reqExt = '0;
  logic reqLast = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic resValid, excUnavail, excIllegal;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  logic [7:0] tS [256];
  logic [7:0] tI [256];
  logic [127:0] expRes = '0;

  always #2 clk = ~clk;

  aesu_top uut (
    .clk(clk), .rst(rst), .vecEnable(vecEnable), .reqValid(reqValid),
    .reqPrimary(reqPrimary), .reqExt(reqExt), .reqLast(reqLast),
    .opA(opA), .opB(opB), .resValid(resValid), .result(result),
    .excUnavail(excUnavail), .excIllegal(excIllegal)
  );

  function automatic logic [7:0] mMul(input logic [7:0] x, input logic [7:0] y);
    int acc = 0;
    int a = x;
    for (int i = 0; i < 8; i++) begin
      if ((y >> i) & 1) acc = acc ^ a;
      a = a << 1;
      if (a > 255) a = a ^ 'h11b;
    end
    return acc[7:0];
  endfunction

  function automatic logic [127:0] refOp(input int kind, input logic [127:0] a, input logic [127:0] b);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] co [4];
    logic [127:0] o;
    for (int k = 0; k < 16; k++) s[k] = a[127-8*k -: 8];
    if (kind == 4) begin
      for (int k = 0; k < 16; k++) t[k] = tS[s[k]];
    end else if (kind < 2) begin
      for (int k = 0; k < 16; k++) t[4*(k/4)+k%4] = tS[s[4*(((k/4)+(k%4))%4)+k%4]];
      for (int k = 0; k < 16; k++) t[k] = t[k];
      if (kind == 0) begin
        co[0] = 2; co[1] = 3; co[2] = 1; co[3] = 1;
        for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) begin
          s[4*c+r] = 0;
          for (int j = 0; j < 4; j++) s[4*c+r] = s[4*c+r] ^ mMul(co[(j-r+4)%4], t[4*c+j]);
        end
        for (int k = 0; k < 16; k++) t[k] = s[k];
      end
      for (int k = 0; k < 16; k++) t[k] = t[k] ^ b[127-8*k -: 8];
    end else begin
      for (int k = 0; k < 16; k++) t[k] = tI[s[4*(((k/4)-(k%4)+4)%4)+k%4]] ^ b[127-8*k -: 8];
      if (kind == 2) begin
        co[0] = 8'h0e; co[1] = 8'h0b; co[2] = 8'h0d; co[3] = 8'h09;
        for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) begin
          s[4*c+r] = 0;
          for (int j = 0; j < 4; j++) s[4*c+r] = s[4*c+r] ^ mMul(co[(j-r+4)%4], t[4*c+j]);
        end
        for (int k = 0; k < 16; k++) t[k] = s[k];
      end
    end
    for (int k = 0; k < 16; k++) o[127-8*k -: 8] = t[k];
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, compare at following negedge after one posedge
  task automatic op(input bit v, input bit en, input logic [5:0] p, input logic [5:0] e,
                    input bit last, input logic [127:0] a, input logic [127:0] b, input string req);
    bit expV, expU, expI, legal;
    int kind;
    reqValid = v; vecEnable = en; reqPrimary = p; reqExt = e; reqLast = last; opA = a; opB = b;
    legal = (p == 4) && (e == 20 || e == 21 || e == 23);
    expV = v && en && legal;
    expU = v && !en;
    expI = v && en && !legal;
    if (expV) begin
      kind = (e == 23) ? 4 : (e == 20) ? (last ? 1 : 0) : (last ? 3 : 2);
      expRes = refOp(kind, a, b);
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(resValid == expV && excUnavail == expU && excIllegal == expI,
          {req, " flags"}, {125'd0, resValid, excUnavail, excIllegal}, {125'd0, expV, expU, expI});
    check(result == expRes, {req, " result"}, result, expRes);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] a0, b0, keep;
    // build reference tables by brute-force inversion
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv, o;
      inv = 0;
      for (int c = 1; c < 256; c++) if (mMul(v[7:0], c[7:0]) == 8'h01) inv = c[7:0];
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      tS[v] = o;
    end
    for (int v = 0; v < 256; v++) tI[tS[v]] = v[7:0];

    repeat (3) @(negedge clk);
    // R11 reset state
    check(!resValid && !excUnavail && !excIllegal && result == 0, "R11 reset", result, 0);
    rst = 1'b0;

    // R5 known S-box values, B and last bit ignored
    op(1, 1, 4, 23, 1, 128'h0, rnd128(), "R5 sbox zero");
    check(result == {16{8'h63}}, "R5 literal 63", result, {16{8'h63}});
    op(1, 1, 4, 23, 0, {8'h53, 120'h0}, 128'h0, "R5 sbox 53");
    check(result[127:120] == 8'hED, "R5 literal ED", {120'd0, result[127:120]}, 128'hED);

    // R1 R2 R3 R4 R7 with random operands
    for (int i = 0; i < 6; i++) begin
      a0 = rnd128(); b0 = rnd128();
      op(1, 1, 4, 20, 0, a0, b0, "R1 fwd round");
      op(1, 1, 4, 20, 1, a0, b0, "R2 R7 fwd last");
      op(1, 1, 4, 21, 0, a0, b0, "R3 inv round");
      op(1, 1, 4, 21, 1, a0, b0, "R4 R7 inv last");
    end

    // R6 round trip with zero key restores A
    a0 = 128'h00112233445566778899aabbccddeeff;
    op(1, 1, 4, 20, 1, a0, 128'h0, "R6 fwd last");
    keep = result;
    op(1, 1, 4, 21, 1, keep, 128'h0, "R6 inv last");
    check(result == a0, "R6 round trip", result, a0);

    // R10 hold over idle cycles
    keep = result;
    for (int i = 0; i < 3; i++) op(0, 1, 4, 20, 0, rnd128(), rnd128(), "R10 idle");
    check(result == keep, "R10 hold", result, keep);

    // R8 disabled request
    op(1, 0, 4, 20, 0, rnd128(), rnd128(), "R8 disabled");
    check(result == keep, "R8 untouched", result, keep);
    // R9 illegal encodings
    op(1, 1, 5, 20, 0, rnd128(), rnd128(), "R9 bad primary");
    op(1, 1, 4, 22, 0, rnd128(), rnd128(), "R9 bad ext");
    op(1, 1, 0, 23, 1, rnd128(), rnd128(), "R9 zero primary");
    check(result == keep, "R9 untouched", result, keep);

    // R12 random mix, back-to-back
    for (int i = 0; i < 300; i++) begin
      logic [5:0] ext;
      int sel = $urandom % 8;
      ext = (sel < 2) ? 6'd20 : (sel < 4) ? 6'd21 : (sel < 6) ? 6'd23 : 6'($urandom);
      op(($urandom % 5) != 0, ($urandom % 6) != 0, ($urandom % 10) == 0 ? 6'd7 : 6'd4,
         ext, $urandom % 2, rnd128(), rnd128(), "R12 random");
    end

    // R11 reset mid-run
    op(1, 1, 4, 20, 0, rnd128(), rnd128(), "R11 pre");
    rst = 1'b1;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    reqValid = 1'b0;
    check(!resValid && !excUnavail && !excIllegal && result == 0, "R11 mid reset", result, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule